// File: doc/BRIEF.md
# Shield Listener: Jam Slot Selector and Masked Codeword Decoder

This block sits on the receive side of a trusted shield device that overhears a tag's backward-channel reply. At a start strobe it arms capture of one codeword. It draws a secret jam slot from its own free-running LFSR, restricted to the first half of the codeword, and holds that slot for the whole word. While the word arrives it raises a jam-enable output in exactly the cycle that the chosen slot's received bit is presented. When the access is not authorized, jam-enable stays high for every slot, and no data is recovered.

Each source bit travels as one of two complementary codewords. The tag has already flipped one bit in the second half of the word before sending it. The shield knows which slot it jammed, so it discards that slot whatever value arrived there. It then compares the remaining bits against both codewords with the same slot masked out. The closer codeword wins, provided it differs in at most one position. The result appears as a one-cycle pulse: either a valid decoded bit or a decode error.

Top module: `shield_listener`

## Requirements
- R1: After reset, and at every cycle with no codeword in progress, jam_o, dec_vld_o and dec_err_o are low.
- R2: A high start_i arms capture of a new codeword and samples auth_i. A start during a codeword abandons the partial word, and that partial word produces no result.
- R3: For an authorized codeword, the jam slot lies in slots 0 to floor(CW_LEN/2)-1. It is fixed at start and held until the word ends.
- R4: For an authorized codeword, jam_o is high in exactly one slot. It is high in the same cycle as that slot's rx_vld_i.
- R5: For an unauthorized codeword, jam_o is high for every slot, and the word ends with dec_err_o instead of a decoded bit.
- R6: Slot k carries bit CW_LEN-1-k of the codeword, so the MSB arrives first. Bit 1 is sent as CODE_ONE, which by default alternates starting with 1 at the MSB (1010101010 for CW_LEN=10). Bit 0 is sent as its complement. Slots advance only on rx_vld_i, so gaps are allowed. Received bits are ignored when no codeword is armed.
- R7: The value received in the jammed slot has no effect on the result.
- R8: With at most one error among the CW_LEN-1 unjammed bits, dec_vld_o pulses with dec_bit_o equal to the source bit.
- R9: When the closer codeword differs in more than one unjammed position, or both codewords are equally close, dec_err_o pulses and dec_vld_o stays low.
- R10: The result pulse lasts exactly one cycle. It comes in the cycle after the last slot's rx_vld_i. dec_vld_o and dec_err_o are never high together.
- R11: The jam slot comes from a free-running LFSR. Slot values outside the allowed range are rejected, so over many codewords more than one slot is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Strobe: arm capture of a codeword |
| auth_i | input | 1 | Access authorized, sampled with start_i |
| rx_bit_i | input | 1 | Received serial bit |
| rx_vld_i | input | 1 | rx_bit_i holds the next slot |
| jam_o | output | 1 | Jam enable for the current slot |
| dec_bit_o | output | 1 | Decoded source bit |
| dec_vld_o | output | 1 | One-cycle pulse: dec_bit_o is valid |
| dec_err_o | output | 1 | One-cycle pulse: codeword rejected |

## Verification
Some properties are checked on every cycle. The jam slot stays inside the first half and holds steady through a word. An authorized word is jammed at most once, and an unauthorized one is jammed in every slot. jam_o is quiet when idle. Results come only one cycle after a last slot, and valid and error are never raised together. Only the bench scenarios can show that the decoder returns the right bit under a tag flip and either jammed-slot value, that double errors are refused, that a restart drops the partial word, and that the LFSR actually spreads its choices across slots.

// File: rtl/shield_pkg.sv
package shield_pkg;

   // Alternating pattern, 1 at the MSB, used as the default bit-one codeword.
   function automatic logic [63:0] alt_word(input int n);
      logic [63:0] w;
      w = '0;
      for (int i = 0; i < n; i++) begin
         w[n-1-i] = (i % 2 == 0);
      end
      return w;
   endfunction

   typedef struct packed {
      logic bit_val;
      logic ok;
      logic err;
   } dec_res_t;

endpackage

// File: rtl/jam_slot_picker.sv
module jam_slot_picker #(
   parameter int                 HALF   = 5,
   parameter int                 IDX_W  = 3,
   parameter int                 LFSR_W = 8,
   parameter logic [LFSR_W-1:0]  TAPS   = 8'hB8,
   parameter logic [LFSR_W-1:0]  SEED   = 8'h5A
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [IDX_W-1:0] pick_o
);

   logic [LFSR_W-1:0] lfsr_q;
   logic              fb;
   logic [IDX_W-1:0]  raw;

   assign fb  = ^(lfsr_q & TAPS);
   assign raw = lfsr_q[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lfsr_q <= SEED;
      else        lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
   end

   generate
      if (HALF == (1 << IDX_W)) begin : g_direct
         assign pick_o = raw;
      end else begin : g_reject
         logic [IDX_W-1:0] cand_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cand_q <= '0;
            else if (int'(raw) < HALF)    cand_q <= raw;
         end
         assign pick_o = cand_q;
      end
   endgenerate

endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
   parameter int CW_LEN = 10,
   parameter int IDX_W  = 3,
   parameter int SLOT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              auth_i,
   input  logic              rx_vld_i,
   input  logic [IDX_W-1:0]  pick_i,
   output logic              active_o,
   output logic              auth_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic              last_hit_o,
   output logic              jam_o
);

   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(CW_LEN - 1);

   logic              act_q, auth_q, jam_q;
   logic [IDX_W-1:0]  idx_q;
   logic [SLOT_W-1:0] slot_q;
   logic              act_d, auth_d;
   logic [IDX_W-1:0]  idx_d;
   logic [SLOT_W-1:0] slot_d;
   logic              step;

   assign step       = act_q && rx_vld_i && !start_i;
   assign last_hit_o = step && (slot_q == LAST);

   always_comb begin
      act_d  = act_q;
      auth_d = auth_q;
      idx_d  = idx_q;
      slot_d = slot_q;
      if (start_i) begin
         act_d  = 1'b1;
         auth_d = auth_i;
         idx_d  = pick_i;
         slot_d = '0;
      end else if (step) begin
         if (slot_q == LAST) begin
            act_d  = 1'b0;
            slot_d = '0;
         end else begin
            slot_d = slot_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         auth_q <= 1'b0;
         idx_q  <= '0;
         slot_q <= '0;
         jam_q  <= 1'b0;
      end else begin
         act_q  <= act_d;
         auth_q <= auth_d;
         idx_q  <= idx_d;
         slot_q <= slot_d;
         jam_q  <= act_d && (!auth_d || (slot_d == SLOT_W'(idx_d)));
      end
   end

   assign active_o = act_q;
   assign auth_o   = auth_q;
   assign idx_o    = idx_q;
   assign slot_o   = slot_q;
   assign jam_o    = jam_q;

endmodule

// File: rtl/masked_decoder.sv
module masked_decoder
   import shield_pkg::*;
#(
   parameter int                CW_LEN   = 10,
   parameter int                IDX_W    = 3,
   parameter logic [CW_LEN-1:0] CODE_ONE = '1
) (
   input  logic [CW_LEN-1:0] word_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              auth_i,
   output dec_res_t          res_o
);

   localparam int DW = $clog2(CW_LEN + 1);

   logic [CW_LEN-1:0] keep;
   logic [DW-1:0]     d_one, d_zero;

   always_comb begin
      keep = '1;
      keep[CW_LEN-1-int'(idx_i)] = 1'b0;
   end

   assign d_one  = DW'($countones((word_i ^  CODE_ONE) & keep));
   assign d_zero = DW'($countones((word_i ^ ~CODE_ONE) & keep));

   always_comb begin
      res_o = '0;
      if (!auth_i) begin
         res_o.err = 1'b1;
      end else if (d_one < d_zero && d_one <= DW'(1)) begin
         res_o.ok      = 1'b1;
         res_o.bit_val = 1'b1;
      end else if (d_zero < d_one && d_zero <= DW'(1)) begin
         res_o.ok      = 1'b1;
         res_o.bit_val = 1'b0;
      end else begin
         res_o.err = 1'b1;
      end
   end

endmodule

// File: rtl/shield_listener.sv
module shield_listener
   import shield_pkg::*;
#(
   parameter int                CW_LEN   = 10,
   parameter logic [CW_LEN-1:0] CODE_ONE = CW_LEN'(shield_pkg::alt_word(CW_LEN)),
   parameter int                LFSR_W   = 8,
   parameter logic [LFSR_W-1:0] TAPS     = 8'hB8,
   parameter logic [LFSR_W-1:0] SEED     = 8'h5A
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic auth_i,
   input  logic rx_bit_i,
   input  logic rx_vld_i,
   output logic jam_o,
   output logic dec_bit_o,
   output logic dec_vld_o,
   output logic dec_err_o
);

   localparam int HALF   = CW_LEN / 2;
   localparam int IDX_W  = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int SLOT_W = $clog2(CW_LEN);

   generate
      if (CW_LEN < 4 || CW_LEN > 64) begin : g_bad_len
         $error("shield_listener: CW_LEN must be within 4..64");
      end
      if (LFSR_W < IDX_W || LFSR_W < 2) begin : g_bad_lfsr
         $error("shield_listener: LFSR_W too narrow for the jam slot");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("shield_listener: SEED must be non-zero");
      end
   endgenerate

   logic [IDX_W-1:0]  pick;
   logic              cw_active, cw_auth, last_hit;
   logic [IDX_W-1:0]  cw_idx;
   logic [SLOT_W-1:0] cw_slot;
   logic [CW_LEN-1:0] shreg_q, word_full;
   dec_res_t          res;
   dec_res_t          out_q;

   jam_slot_picker #(
      .HALF(HALF), .IDX_W(IDX_W), .LFSR_W(LFSR_W), .TAPS(TAPS), .SEED(SEED)
   ) u_pick (
      .clk(clk), .rst_n(rst_n), .pick_o(pick)
   );

   slot_sequencer #(
      .CW_LEN(CW_LEN), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .auth_i(auth_i),
      .rx_vld_i(rx_vld_i), .pick_i(pick), .active_o(cw_active),
      .auth_o(cw_auth), .idx_o(cw_idx), .slot_o(cw_slot),
      .last_hit_o(last_hit), .jam_o(jam_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    shreg_q <= '0;
      else if (start_i)                              shreg_q <= '0;
      else if (cw_active && rx_vld_i)                shreg_q <= {shreg_q[CW_LEN-2:0], rx_bit_i};
   end

   assign word_full = {shreg_q[CW_LEN-2:0], rx_bit_i};

   masked_decoder #(
      .CW_LEN(CW_LEN), .IDX_W(IDX_W), .CODE_ONE(CODE_ONE)
   ) u_dec (
      .word_i(word_full), .idx_i(cw_idx), .auth_i(cw_auth), .res_o(res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        out_q <= '0;
      else if (last_hit) out_q <= res;
      else               out_q <= '{bit_val: out_q.bit_val, ok: 1'b0, err: 1'b0};
   end

   assign dec_bit_o = out_q.bit_val;
   assign dec_vld_o = out_q.ok;
   assign dec_err_o = out_q.err;

endmodule

// File: rtl/shield_listener_chk.sv
module shield_listener_chk #(
   parameter int CW_LEN = 10,
   parameter int IDX_W  = 3,
   parameter int SLOT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              rx_vld_i,
   input logic              jam_o,
   input logic              dec_vld_o,
   input logic              dec_err_o,
   input logic              cw_active,
   input logic              cw_auth,
   input logic [IDX_W-1:0]  cw_idx,
   input logic [SLOT_W-1:0] cw_slot
);

   localparam int HALF = CW_LEN / 2;
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(CW_LEN - 1);

   logic jam_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              jam_seen <= 1'b0;
      else if (start_i)                        jam_seen <= 1'b0;
      else if (cw_active && rx_vld_i && jam_o) jam_seen <= 1'b1;
   end

   // R1
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cw_active |-> !jam_o);

   // R3
   p_jam_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_active && cw_auth && jam_o) |-> (int'(cw_slot) < HALF));

   p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_active && $past(cw_active) && !$past(start_i)) |-> $stable(cw_idx));

   // R4
   p_single_jam_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_active && cw_auth && rx_vld_i && jam_o && !start_i) |-> !jam_seen);

   // R5
   p_unauth_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_active && !cw_auth) |-> jam_o);

   // R10
   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld_o |-> !dec_err_o);

   p_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld_o || dec_err_o) |->
         $past(cw_active && rx_vld_i && !start_i && cw_slot == LAST));

   p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld_o || dec_err_o) |=> !(dec_vld_o || dec_err_o));

endmodule

bind shield_listener shield_listener_chk #(
   .CW_LEN(CW_LEN), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_vld_i(rx_vld_i),
   .jam_o(jam_o), .dec_vld_o(dec_vld_o), .dec_err_o(dec_err_o),
   .cw_active(cw_active), .cw_auth(cw_auth), .cw_idx(cw_idx), .cw_slot(cw_slot)
);

// File: tb/tb_shield_listener.sv
module tb_shield_listener;

   localparam int L = 10;
   localparam int H = L / 2;
   localparam logic [L-1:0] C1 = 10'b1010101010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, auth_i = 1'b0, rx_bit_i = 1'b0, rx_vld_i = 1'b0;
   logic jam_o, dec_bit_o, dec_vld_o, dec_err_o;

   int checks = 0;
   int errors = 0;
   logic [1:0] expq[$];       // {err, bit}
   int slot_hist[H];

   always #4 clk = ~clk;      // 125 MHz

   shield_listener dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .auth_i(auth_i),
      .rx_bit_i(rx_bit_i), .rx_vld_i(rx_vld_i), .jam_o(jam_o),
      .dec_bit_o(dec_bit_o), .dec_vld_o(dec_vld_o), .dec_err_o(dec_err_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard whenever the design reports a result.
   always @(negedge clk) begin
      if (rst_n && (dec_vld_o || dec_err_o)) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R10 unexpected result", {dec_err_o, dec_vld_o}, 0);
         end else begin
            logic [1:0] e;
            e = expq.pop_front();
            if (e[1]) chk(dec_err_o && !dec_vld_o, "R9/R5 error pulse",
                          {dec_err_o, dec_vld_o}, 2);
            else begin
               chk(dec_vld_o && !dec_err_o, "R8 valid pulse", {dec_err_o, dec_vld_o}, 1);
               chk(dec_bit_o == e[0], "R8/R7 decoded bit", dec_bit_o, e[0]);
            end
         end
      end
   end

   // Driver: one codeword. jmode 0/1 forces the jammed-slot flip, 2 picks at random.
   task automatic send_word(input logic b, input logic au, input int nflip,
                            input int gap, input int jmode);
      logic [L-1:0] cw, fl;
      int jams, jslot, cnt, e, o;
      logic jv;
      cw = b ? C1 : ~C1;
      fl = '0;
      cnt = 0;
      while (cnt < nflip) begin
         int s;
         s = H + int'($urandom % (L - H));
         if (!fl[L-1-s]) begin fl[L-1-s] = 1'b1; cnt++; end
      end
      jv = (jmode == 2) ? 1'($urandom % 2) : 1'(jmode);
      e = nflip;
      o = (L - 1) - nflip;
      if (!au)                 expq.push_back(2'b10);
      else if (e < o && e <= 1) expq.push_back({1'b0, b});
      else if (o < e && o <= 1) expq.push_back({1'b0, ~b});
      else                     expq.push_back(2'b10);
      @(negedge clk); start_i = 1'b1; auth_i = au;
      @(negedge clk); start_i = 1'b0;
      jams = 0; jslot = -1;
      for (int k = 0; k < L; k++) begin
         if (k > 0) @(negedge clk);
         if (gap > 0 && k == 3) begin
            rx_vld_i = 1'b0;
            repeat (gap) @(negedge clk);
         end
         if (jam_o) begin jams++; jslot = k; end
         rx_bit_i = cw[L-1-k] ^ fl[L-1-k] ^ (jam_o & jv);
         rx_vld_i = 1'b1;
      end
      @(negedge clk); rx_vld_i = 1'b0;
      if (au) begin
         chk(jams == 1, "R4 one jammed slot", jams, 1);
         chk(jslot >= 0 && jslot < H, "R3 jam slot in first half", jslot, H - 1);
         if (jslot >= 0 && jslot < H) slot_hist[jslot]++;
      end else begin
         chk(jams == L, "R5 all slots jammed", jams, L);
      end
   endtask

   initial begin
      #(8 * 150000);
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < H; i++) slot_hist[i] = 0;
      repeat (3) @(negedge clk);
      chk(jam_o == 0 && dec_vld_o == 0 && dec_err_o == 0, "R1 reset outputs",
          {jam_o, dec_vld_o, dec_err_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(jam_o == 0, "R1 idle jam", jam_o, 0);

      // R6: bits while idle are ignored, jam stays low, no result.
      for (int i = 0; i < 6; i++) begin
         rx_bit_i = 1'($urandom % 2); rx_vld_i = 1'b1;
         @(negedge clk);
         chk(jam_o == 0, "R6 idle bits ignored", jam_o, 0);
      end
      rx_vld_i = 1'b0;

      // R8: clean and single-flip words, both bit values.
      send_word(1'b1, 1'b1, 0, 0, 0);
      send_word(1'b0, 1'b1, 0, 0, 1);
      send_word(1'b1, 1'b1, 1, 0, 0);
      send_word(1'b0, 1'b1, 1, 0, 1);
      // R7: same word with jammed slot left and flipped.
      send_word(1'b1, 1'b1, 1, 0, 1);
      send_word(1'b1, 1'b1, 1, 0, 0);
      // R6: gaps in rx_vld_i.
      send_word(1'b0, 1'b1, 1, 4, 2);
      send_word(1'b1, 1'b1, 0, 2, 2);
      // R9: two and three errors refused.
      send_word(1'b1, 1'b1, 2, 0, 2);
      send_word(1'b0, 1'b1, 3, 0, 2);
      // R5: unauthorized.
      send_word(1'b1, 1'b0, 0, 0, 2);
      send_word(1'b0, 1'b0, 1, 1, 2);

      // R2: restart mid-word drops the partial word.
      @(negedge clk); start_i = 1'b1; auth_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      for (int k = 0; k < 4; k++) begin
         rx_bit_i = C1[L-1-k]; rx_vld_i = 1'b1; @(negedge clk);
      end
      rx_vld_i = 1'b0;
      send_word(1'b0, 1'b1, 1, 0, 2);

      // R11: many authorized words, randomized content and spacing.
      for (int n = 0; n < 40; n++) begin
         repeat ($urandom % 3) @(negedge clk);
         send_word(1'($urandom % 2), 1'b1, int'($urandom % 2), 0, 2);
      end

      repeat (4) @(negedge clk);
      chk(jam_o == 0, "R1 idle after words", jam_o, 0);
      chk(expq.size() == 0, "R10 every word produced a result", expq.size(), 0);
      begin
         int used;
         used = 0;
         for (int i = 0; i < H; i++) if (slot_hist[i] > 0) used++;
         chk(used >= 2, "R11 jam slot varies", used, 2);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule